// File: doc/BRIEF.md
# IPv4 Header Check Stage

This stage sits in a 32-bit packet stream between a frame-level receiver and a payload-level consumer. Each packet arrives as a run of words bounded by a start-of-packet flag on the first word and an end-of-packet flag on the last word. The stage holds the IPv4 header back in a local store until the header has been judged. Only then does it pass the header on. A packet with the wrong version, a malformed header length, a checksum that does not verify, or a truncated header never shows a single word at the output.

When the TTL-decrement option is selected, the stage lowers the TTL of each forwarded packet by one. It then writes a corrected header checksum, so the outgoing header still verifies. A packet whose TTL would reach zero is discarded instead. IP options inside the header are carried through unchanged. The first word after the header is marked with a start-of-payload strobe, so the next stage can find the transport data without parsing the header. Both sides use a valid/ready handshake. A stalled consumer therefore stalls the producer without losing or repeating words.

Top module: `ipv4_hdr_check`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A header with version 4, IHL of 5 and a correct checksum is forwarded word for word when decrement is off. `out_sop` marks word 0, and `out_eop` marks the last word of the packet. Word 0 carries version in bits 31:28 and IHL in bits 27:24.
- R3: A packet whose version field (word 0 bits 31:28) is not 4 produces no output word.
- R4: A packet whose header halves (16-bit, ones-complement sum with end-around carry) do not sum to 0xFFFF produces no output word.
- R5: A packet with IHL below 5 produces no output word.
- R6: With `cfg_ttl_dec` sampled as 1 on the start word, the TTL (word 2 bits 31:24) goes out reduced by one. The checksum (word 2 bits 15:0) is rewritten so the forwarded header again sums to 0xFFFF. All other words are unchanged.
- R7: With decrement selected, a packet arriving with TTL 0 or 1 is dropped. With decrement off, the same packet is forwarded.
- R8: `out_pld` is high on exactly the first word after the header. It never rises for a packet that ends with its header.
- R9: Headers with options (IHL above 5) are forwarded in full, and the start-of-payload mark follows the last option word.
- R10: While `out_valid` is high and `out_ready` is low, the output word and its flags stay stable. No input word is lost or duplicated under any stall pattern.
- R11: A packet whose end-of-packet comes before the header is complete is dropped. Words that arrive outside a packet (without a preceding start word) are discarded.
- R12: After any dropped packet, the next valid packet is forwarded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_ttl_dec | input | 1 | Select TTL decrement; sampled with each start word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage accepts the input word |
| in_data | input | 32 | Input word |
| in_sop | input | 1 | Input word is the first of a packet |
| in_eop | input | 1 | Input word is the last of a packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | Output word is the first of a packet |
| out_eop | output | 1 | Output word is the last of a packet |
| out_pld | output | 1 | Output word is the first payload word |

## Verification
Some behaviours are checked by assertions on every cycle:
- output stability under stall;
- every emitted start word carrying version 4 and IHL of at least 5;
- the payload mark never coinciding with a start word;
- a decremented TTL never leaving as zero;
- header store indices staying in range.

Other behaviours only the directed scenarios can show, because they depend on whole packets:
- the complete absence of output for bad version, checksum, length, TTL and truncation;
- the exact rewritten checksum;
- the placement of the payload mark after options;
- word-exact delivery under a stall pattern;
- recovery after drops.

// File: rtl/ipv4_hc_pkg.sv
// Package ipv4_hc_pkg
// Shared constants and the control state type of the IPv4 header check stage.
// Assumes 32-bit words with the IPv4 header aligned to word 0 of each packet.
package ipv4_hc_pkg;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = 16;
    localparam int MIN_IHL  = 5;
    localparam int IP_VER   = 4;
    localparam int TTL_WORD = 2;     // word index holding TTL, protocol, checksum

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start word
        ST_HDR,    // collecting header words
        ST_CHECK,  // judging the collected header
        ST_EMIT,   // replaying the stored header
        ST_PASS,   // streaming payload straight through
        ST_DROP    // discarding the rest of a rejected packet
    } hc_state_t;
endpackage

// File: rtl/ipv4_ck_accum.sv
// Module ipv4_ck_accum
// Running ones-complement sum of 16-bit halves of header words.
// `start` loads the first word, `add` accumulates further words; `folded`
// gives the end-around-carry result. Assumes at most MAX_WORDS words per sum.
module ipv4_ck_accum #(
    parameter int W         = 32,
    parameter int MAX_WORDS = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          add,
    input  logic [W-1:0]  word,
    output logic [15:0]   folded
);
    localparam int HALVES = (W / 16) * MAX_WORDS;
    localparam int SUM_W  = 16 + $clog2(HALVES);
    localparam int TOP_W  = SUM_W - 16;

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] word_sum;
    logic [16:0]      fold1;

    // Sum of both halves of the incoming word
    always_comb begin
        word_sum = SUM_W'(word[31:16]) + SUM_W'(word[15:0]);
    end

    // Load on start, accumulate on add
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (start)  sum_q <= word_sum;
        else if (add)    sum_q <= sum_q + word_sum;
    end

    // Two end-around folds bring the wide sum back to 16 bits
    always_comb begin
        fold1  = {1'b0, sum_q[15:0]} + 17'(sum_q[SUM_W-1 -: TOP_W]);
        folded = fold1[15:0] + 16'(fold1[16]);
    end

    // a_r4_no_double_load: start and add never requested together
    a_r4_no_double_load: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && add));
endmodule

// File: rtl/ipv4_hdr_buf.sv
// Module ipv4_hdr_buf
// Storage for up to DEPTH header words; one write port, one combinational
// read port. Assumes the writer never addresses beyond DEPTH-1.
module ipv4_hdr_buf #(
    parameter int W     = 32,
    parameter int DEPTH = 15,
    localparam int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] mem [DEPTH];

    // One register per slot, written when its index is selected
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                             mem[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))  mem[g] <= wr_data;
        end
    end

    // Read port
    always_comb begin
        rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;
    end

    // a_r9_wr_in_range: writes stay inside the store
    a_r9_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < DEPTH));
endmodule

// File: rtl/ipv4_ttl_patch.sv
// Module ipv4_ttl_patch
// Rewrites the TTL/protocol/checksum word: TTL minus one and an incremental
// checksum fix (lowering the upper byte of a half by one raises the stored
// complement by 0x0100 with end-around carry). Assumes TTL >= 1 on input.
module ipv4_ttl_patch #(
    parameter int W = 32
) (
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_out
);
    logic [16:0] raised;
    logic [15:0] new_ck;

    // Incremental checksum correction and TTL decrement
    always_comb begin
        raised   = {1'b0, word_in[15:0]} + 17'h0_0100;
        new_ck   = raised[15:0] + 16'(raised[16]);
        word_out = {word_in[31:24] - 8'd1, word_in[23:16], new_ck};
    end
endmodule

// File: rtl/ipv4_hdr_check.sv
// Module ipv4_hdr_check
// Streaming IPv4 header check. Stores the header (IHL words), verifies
// version, IHL and checksum, optionally decrements TTL with checksum fix,
// then replays the header and streams the payload with a first-payload mark.
// Rejected or truncated packets are consumed with no output at all.
// Assumes the header starts at word 0 and cfg_ttl_dec is valid on start words.
module ipv4_hdr_check
    import ipv4_hc_pkg::*;
#(
    parameter int HDR_MAX = 15,
    localparam int IDX_W  = $clog2(HDR_MAX + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_ttl_dec,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    input  logic        in_sop,
    input  logic        in_eop,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_sop,
    output logic        out_eop,
    output logic        out_pld
);
    hc_state_t        state_q;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] ihl_q;
    logic             ver_ok_q;
    logic [7:0]       ttl_q;
    logic             dec_q;
    logic             hdr_eop_q;
    logic             pld_pend_q;

    logic             in_fire;
    logic             out_fire;
    logic             acc_start;
    logic             acc_add;
    logic [15:0]      ck_fold;
    logic             buf_wr;
    logic [IDX_W-1:0] buf_wr_idx;
    logic [31:0]      buf_rd;
    logic [31:0]      patched;
    logic             hdr_last_in;
    logic             emit_last;
    logic             hdr_good;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    // Header word index decode for the collect and replay phases
    always_comb begin
        hdr_last_in = (cnt_q == ihl_q - IDX_W'(1));
        emit_last   = (cnt_q == ihl_q - IDX_W'(1));
        hdr_good    = (ck_fold == 16'hFFFF) && ver_ok_q &&
                      (!dec_q || (ttl_q >= 8'd2));
    end

    // Store and accumulator controls
    always_comb begin
        acc_start  = (state_q == ST_IDLE) && in_fire && in_sop;
        acc_add    = (state_q == ST_HDR) && in_fire;
        buf_wr     = acc_start || acc_add;
        buf_wr_idx = acc_start ? '0 : cnt_q;
    end

    ipv4_ck_accum #(.W(32), .MAX_WORDS(HDR_MAX)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (acc_start),
        .add    (acc_add),
        .word   (in_data),
        .folded (ck_fold)
    );

    ipv4_hdr_buf #(.W(32), .DEPTH(HDR_MAX)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_idx  (buf_wr_idx),
        .wr_data (in_data),
        .rd_idx  (cnt_q),
        .rd_data (buf_rd)
    );

    ipv4_ttl_patch #(.W(32)) u_patch (
        .word_in  (buf_rd),
        .word_out (patched)
    );

    // Handshake and output word selection per state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        out_pld   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_HDR, ST_DROP: in_ready = 1'b1;
            ST_CHECK: ;
            ST_EMIT: begin
                out_valid = 1'b1;
                out_data  = (dec_q && cnt_q == IDX_W'(TTL_WORD)) ? patched : buf_rd;
                out_sop   = (cnt_q == '0);
                out_eop   = emit_last && hdr_eop_q;
            end
            ST_PASS: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_eop   = in_eop;
                out_pld   = pld_pend_q && in_valid;
            end
            default: ;
        endcase
    end

    // Packet control sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            ihl_q      <= '0;
            ver_ok_q   <= 1'b0;
            ttl_q      <= '0;
            dec_q      <= 1'b0;
            hdr_eop_q  <= 1'b0;
            pld_pend_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (in_fire && in_sop) begin
                    ihl_q    <= IDX_W'(in_data[27:24]);
                    ver_ok_q <= (in_data[31:28] == 4'(IP_VER));
                    dec_q    <= cfg_ttl_dec;
                    cnt_q    <= IDX_W'(1);
                    if (in_eop)                               state_q <= ST_IDLE;
                    else if (in_data[27:24] < 4'(MIN_IHL))    state_q <= ST_DROP;
                    else                                      state_q <= ST_HDR;
                end
                ST_HDR: if (in_fire) begin
                    if (cnt_q == IDX_W'(TTL_WORD)) ttl_q <= in_data[31:24];
                    cnt_q <= cnt_q + IDX_W'(1);
                    if (hdr_last_in) begin
                        hdr_eop_q <= in_eop;
                        state_q   <= ST_CHECK;
                    end else if (in_eop) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_CHECK: begin
                    cnt_q <= '0;
                    if (hdr_good)       state_q <= ST_EMIT;
                    else if (hdr_eop_q) state_q <= ST_IDLE;
                    else                state_q <= ST_DROP;
                end
                ST_EMIT: if (out_fire) begin
                    if (emit_last) begin
                        pld_pend_q <= !hdr_eop_q;
                        state_q    <= hdr_eop_q ? ST_IDLE : ST_PASS;
                    end else begin
                        cnt_q <= cnt_q + IDX_W'(1);
                    end
                end
                ST_PASS: if (in_fire) begin
                    pld_pend_q <= 1'b0;
                    if (in_eop) state_q <= ST_IDLE;
                end
                ST_DROP: if (in_fire && in_eop) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // a_r10_hold_stalled: a stalled output word and its flags do not change
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_sop) && $stable(out_eop)));

    // a_r3_version_out: every emitted start word carries version 4
    a_r3_version_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_data[31:28] == 4'(IP_VER)));

    // a_r5_ihl_out: every emitted start word has a legal header length
    a_r5_ihl_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_data[27:24] >= 4'(MIN_IHL)));

    // a_r8_pld_apart: the payload mark is never on a start word
    a_r8_pld_apart: assert property (@(posedge clk) disable iff (!rst_n)
        out_pld |-> (out_valid && !out_sop));

    // a_r7_ttl_nonzero: a decremented TTL never leaves as zero
    a_r7_ttl_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT && dec_q && cnt_q == IDX_W'(TTL_WORD))
            |-> (out_data[31:24] != 8'd0));

    // a_r1_no_out_idle: nothing leaves while a header is still collected
    a_r1_no_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR || state_q == ST_CHECK) |-> !out_valid);
endmodule

// File: tb/ipv4_hdr_check_tb.sv
module ipv4_hdr_check_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ttl_dec = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;
    logic        out_pld;

    int n_checks = 0;
    int n_fail   = 0;
    bit stall_on = 1'b0;
    bit finished = 1'b0;
    int cyc      = 0;

    logic [31:0] pkt_q [$];
    logic [34:0] exp_q [$];
    logic [34:0] cap_q [$];

    always #10 clk = ~clk;   // 50 MHz

    ipv4_hdr_check u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ttl_dec(cfg_ttl_dec),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_pld(out_pld)
    );

    // Consumer ready pattern, changed on falling edges
    initial forever begin
        @(negedge clk);
        cyc++;
        out_ready = !stall_on || (cyc % 3 == 0);
    end

    // Output monitor, sampled a quarter period before the rising edge
    initial forever begin
        @(negedge clk);
        #5;
        if (out_valid && out_ready) cap_q.push_back({out_pld, out_sop, out_eop, out_data});
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fold_sum(input int ihl, input bit zero_ck);
        logic [31:0] s = 0;
        for (int i = 0; i < ihl; i++) begin
            logic [31:0] w = pkt_q[i];
            if (zero_ck && i == 2) w[15:0] = 16'h0;
            s += w[31:16] + w[15:0];
        end
        while (s[31:16] != 0) s = s[15:0] + s[31:16];
        return s[15:0];
    endfunction

    // Builds a packet into pkt_q with a correct checksum unless bad_ck
    task automatic build(input logic [3:0] ver, input logic [3:0] ihl, input logic [7:0] ttl,
                         input int npay, input bit bad_ck);
        int hl = (ihl < 5) ? 5 : ihl;
        pkt_q.delete();
        pkt_q.push_back({ver, ihl, 8'h00, 16'((hl + npay) * 4)});
        pkt_q.push_back({16'h1C46, 16'h4000});
        pkt_q.push_back({ttl, 8'd17, 16'h0000});
        pkt_q.push_back(32'h0A00_0001);
        pkt_q.push_back(32'hC0A8_0101);
        for (int i = 5; i < hl; i++) pkt_q.push_back(32'h0101_0100 + i);
        pkt_q[2][15:0] = ~fold_sum(hl, 1'b1) ^ (bad_ck ? 16'h0040 : 16'h0);
        for (int i = 0; i < npay; i++) pkt_q.push_back(32'hD000_0000 + i);
    endtask

    task automatic make_exp(input bit fwd, input bit dec);
        int ihl = pkt_q[0][27:24];
        logic [31:0] w2_save = pkt_q[2];
        exp_q.delete();
        if (!fwd) return;
        if (dec) begin
            pkt_q[2][31:24] = pkt_q[2][31:24] - 8'd1;
            pkt_q[2][15:0]  = ~fold_sum(ihl, 1'b1);
        end
        for (int i = 0; i < pkt_q.size(); i++)
            exp_q.push_back({(i == ihl), (i == 0), (i == pkt_q.size() - 1), pkt_q[i]});
        pkt_q[2] = w2_save;
    endtask

    task automatic send(input bit dec);
        for (int i = 0; i < pkt_q.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pkt_q[i];
            in_sop = (i == 0); in_eop = (i == pkt_q.size() - 1);
            cfg_ttl_dec = dec;
            #5;
            while (!in_ready) begin @(negedge clk); #5; end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic run_pkt(input bit dec, input bit fwd, input string req);
        make_exp(fwd, dec);
        cap_q.delete();
        send(dec);
        repeat (40) @(negedge clk);
        check(cap_q.size() == exp_q.size(), {req, " word count"}, 64'(cap_q.size()),
              64'(exp_q.size()));
        for (int i = 0; i < cap_q.size() && i < exp_q.size(); i++)
            check(cap_q[i] == exp_q[i], req, 64'(cap_q[i]), 64'(exp_q[i]));
    endtask

    task automatic t_reset();   // R1
        check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'(0));
        check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'(1));
    endtask

    task automatic t_basic();   // R2 R8
        build(4'd4, 4'd5, 8'd64, 3, 1'b0);
        run_pkt(1'b0, 1'b1, "R2 R8 basic");
    endtask

    task automatic t_no_payload();   // R8
        build(4'd4, 4'd5, 8'd64, 0, 1'b0);
        run_pkt(1'b0, 1'b1, "R8 header only");
    endtask

    task automatic t_options();   // R9
        build(4'd4, 4'd7, 8'd30, 2, 1'b0);
        run_pkt(1'b0, 1'b1, "R9 options");
        build(4'd4, 4'd15, 8'd30, 1, 1'b0);
        run_pkt(1'b1, 1'b1, "R9 max header");
    endtask

    task automatic t_ttl_dec();   // R6
        build(4'd4, 4'd5, 8'd64, 2, 1'b0);
        run_pkt(1'b1, 1'b1, "R6 ttl decrement");
        build(4'd4, 4'd5, 8'd2, 1, 1'b0);
        run_pkt(1'b1, 1'b1, "R6 ttl 2 to 1");
    endtask

    task automatic t_ttl_low();   // R7
        build(4'd4, 4'd5, 8'd1, 2, 1'b0);
        run_pkt(1'b1, 1'b0, "R7 ttl 1 dropped");
        build(4'd4, 4'd5, 8'd0, 2, 1'b0);
        run_pkt(1'b1, 1'b0, "R7 ttl 0 dropped");
        build(4'd4, 4'd5, 8'd1, 2, 1'b0);
        run_pkt(1'b0, 1'b1, "R7 ttl 1 kept without decrement");
    endtask

    task automatic t_bad_version();   // R3
        build(4'd6, 4'd5, 8'd64, 3, 1'b0);
        run_pkt(1'b0, 1'b0, "R3 version 6");
    endtask

    task automatic t_bad_ck();   // R4
        build(4'd4, 4'd5, 8'd64, 3, 1'b1);
        run_pkt(1'b0, 1'b0, "R4 bad checksum");
        build(4'd4, 4'd5, 8'd64, 0, 1'b1);
        run_pkt(1'b0, 1'b0, "R4 bad checksum header only");
    endtask

    task automatic t_bad_ihl();   // R5
        build(4'd4, 4'd4, 8'd64, 3, 1'b0);
        run_pkt(1'b0, 1'b0, "R5 ihl 4");
    endtask

    task automatic t_trunc();   // R11
        build(4'd4, 4'd5, 8'd64, 0, 1'b0);
        void'(pkt_q.pop_back());
        void'(pkt_q.pop_back());
        run_pkt(1'b0, 1'b0, "R11 truncated header");
        // stray word without a start flag
        cap_q.delete();
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'hBAD0_0001; in_sop = 1'b0; in_eop = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
        repeat (10) @(negedge clk);
        check(cap_q.size() == 0, "R11 stray word", 64'(cap_q.size()), 64'(0));
    endtask

    task automatic t_recover();   // R12
        build(4'd4, 4'd6, 8'd9, 4, 1'b0);
        run_pkt(1'b1, 1'b1, "R12 after drops");
    endtask

    task automatic t_stall();   // R10
        stall_on = 1'b1;
        build(4'd4, 4'd6, 8'd50, 5, 1'b0);
        run_pkt(1'b1, 1'b1, "R10 stalled output");
        stall_on = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        t_reset();
        t_basic();
        t_no_payload();
        t_options();
        t_ttl_dec();
        t_ttl_low();
        t_bad_version();
        t_bad_ck();
        t_bad_ihl();
        t_trunc();
        t_recover();
        t_stall();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule